// File: doc/BRIEF.md
# Multi-Mode Bit Clock Recovery Loop

This block recovers a bit clock from the sign of a received baseband signal. An oversample enable marks the phase steps, 16 per bit by default. On each step a phase register moves forward by one step. The block watches the sign stream for zero crossings and measures how far each crossing lands from the bit boundary the loop expects. It then pulls its phase toward the crossings. How hard it pulls is set by two control inputs.

While the acquire input is high, each crossing corrects the phase by the full measured error, so lock comes within a few crossings. When acquire drops, the loop runs with a medium bandwidth for 30 recovered bits and then moves on to a narrow bandwidth by itself. In both tracking modes the errors of two crossings are summed and the resulting correction is limited. Pulling the tracking input low while acquire is low opens the loop, and the clock then runs freely at its nominal rate through a fade.

The block has three outputs. The recovered clock has a 50% duty cycle and rises at mid-bit. A one-cycle strobe marks the mid-bit sample point. The integer phase step is also brought out, so that a downstream quality detector can compare crossings against the expected boundary.

Top module: `bitclk_dpll`

## Requirements
- R1: Internally, reset is held until two clock edges after `rst_n` rises. While reset is held, `exp_phase` is 0 and `rx_clk` and `mid_strobe` are 0.
- R2: The phase advances only on cycles where `os_en` is 1. With no zero crossing, each `os_en` tick advances `exp_phase` by exactly one step, modulo `STEPS_PER_BIT`. In cycles without `os_en` the phase does not change.
- R3: `rx_clk` is 1 while `exp_phase` is in the upper half of the bit (8..15 by default), which is 8 of every 16 ticks when free running. `mid_strobe` is a single-cycle pulse, one per bit. It is raised in the cycle after the tick that takes the phase into the upper half.
- R4: A zero crossing is an `os_en` tick on which `rx_sign` differs from its value at the previous `os_en` tick. The reset value of `rx_sign` is taken as 0. The phase error is the fine phase at that tick, read as a signed number, so phases in the upper half of the bit count as negative. One step equals 4 fine units.
- R5: While `acq_req` is 1, a crossing with `ACQ_SHIFT`=0 subtracts the whole error. After that tick, `exp_phase` is therefore 1 whatever the phase was before. `track_en` has no effect in this mode.
- R6: In medium mode the first crossing of a pair applies no correction. The second crossing applies the negated sum of the two errors, clamped to ±1/16 bit (±1 step).
- R7: In narrow mode the pair correction is clamped to ±1/64 bit (±1 fine unit).
- R8: After `acq_req` falls, the loop stays in medium mode until 30 `mid_strobe` pulses have been counted while `track_en` was 1. After that it runs in narrow mode. The count is cleared while `acq_req` is 1 and does not advance while `track_en` is 0. After reset, counting starts from zero.
- R9: With `acq_req`=0 and `track_en`=0, crossings apply no correction and any half-collected pair is discarded. The phase and `rx_clk` keep advancing one step per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_en | input | 1 | Oversample tick: one phase step per pulse |
| rx_sign | input | 1 | Sliced sign of the received baseband signal |
| acq_req | input | 1 | 1 selects acquire mode |
| track_en | input | 1 | 1 lets the loop track; 0 with acq_req 0 freewheels |
| rx_clk | output | 1 | Recovered bit clock, rising at mid-bit |
| mid_strobe | output | 1 | One-cycle mid-bit sample pulse |
| exp_phase | output | $clog2(STEPS_PER_BIT) | Integer phase step; 0 is the expected crossing point |

## Verification
The hardest behaviour to observe from the ports is the difference between medium and narrow mode. For a single pair of crossings, both clamps give the same integer phase, because the fine bits are hidden. The stimulus therefore places four crossings on consecutive ticks, all with positive error, so that two clamped corrections add up. Medium mode then ends one step behind narrow mode. To reach each mode, the bench runs long stretches of 640 quiet ticks: once with tracking enabled, so the 30-bit timer expires, and once with tracking disabled, to show that the timer stays frozen and medium mode survives the fade.

// File: rtl/bitclk_dpll_pkg.sv
package bitclk_dpll_pkg;

  typedef enum logic [1:0] {
    MODE_ACQ  = 2'd0,
    MODE_MED  = 2'd1,
    MODE_NAR  = 2'd2,
    MODE_HOLD = 2'd3
  } loop_mode_e;

endpackage

// File: rtl/bitclk_xing_det.sv
module bitclk_xing_det #(
  parameter int PH_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   os_en,
  input  logic                   rx_sign,
  input  logic [PH_W-1:0]        ph,
  output logic                   xing,
  output logic signed [PH_W-1:0] err
);

  logic sign_q;
  logic sign_d;

  // Remember the sign seen on the last oversample tick.
  always_comb begin
    sign_d = sign_q;
    if (os_en) sign_d = rx_sign;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sign_q <= 1'b0;
    else        sign_q <= sign_d;
  end

  assign xing = os_en & (rx_sign ^ sign_q);
  // Boundary sits at phase zero, so the raw phase read as signed is the error.
  assign err  = $signed(ph);

endmodule

// File: rtl/bitclk_mode_ctrl.sv
module bitclk_mode_ctrl
  import bitclk_dpll_pkg::*;
#(
  parameter int MED_BITS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acq_req,
  input  logic       track_en,
  input  logic       bit_tick,
  output loop_mode_e mode
);

  localparam int CNT_W = $clog2(MED_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(MED_BITS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (acq_req)
      cnt_d = '0;
    else if (track_en && bit_tick && (cnt_q < CNT_END))
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    if (acq_req)              mode = MODE_ACQ;
    else if (!track_en)       mode = MODE_HOLD;
    else if (cnt_q < CNT_END) mode = MODE_MED;
    else                      mode = MODE_NAR;
  end

endmodule

// File: rtl/bitclk_phase_nco.sv
module bitclk_phase_nco
  import bitclk_dpll_pkg::*;
#(
  parameter int PH_W      = 6,
  parameter int FINE_BITS = 2,
  parameter int MED_LIM   = 4,
  parameter int NAR_LIM   = 1,
  parameter int ACQ_SHIFT = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   os_en,
  input  logic                   xing,
  input  logic signed [PH_W-1:0] err,
  input  loop_mode_e             mode,
  output logic [PH_W-1:0]        ph,
  output logic                   strobe
);

  localparam int XW = PH_W + 2;
  localparam logic [PH_W-1:0]      STEP  = PH_W'(1 << FINE_BITS);
  localparam logic signed [XW-1:0] MED_S = XW'(MED_LIM);
  localparam logic signed [XW-1:0] NAR_S = XW'(NAR_LIM);

  logic [PH_W-1:0]        ph_q, ph_d;
  logic                   msb_q;
  logic                   half_q, half_d;
  logic signed [PH_W:0]   acc_q, acc_d;

  logic signed [XW-1:0]   err_x, sum_x, neg_x, lim_x, corr;

  always_comb begin
    err_x  = XW'(err);
    sum_x  = XW'(acc_q) + err_x;
    neg_x  = -sum_x;
    lim_x  = (mode == MODE_MED) ? MED_S : NAR_S;
    corr   = '0;
    half_d = half_q;
    acc_d  = acc_q;
    ph_d   = ph_q;
    if (os_en) begin
      case (mode)
        MODE_ACQ: begin
          half_d = 1'b0;
          acc_d  = '0;
          if (xing) corr = -(err_x >>> ACQ_SHIFT);
        end
        MODE_HOLD: begin
          half_d = 1'b0;
          acc_d  = '0;
        end
        default: begin
          if (xing) begin
            if (!half_q) begin
              half_d = 1'b1;
              acc_d  = (PH_W+1)'(err_x);
            end else begin
              half_d = 1'b0;
              acc_d  = '0;
              if (neg_x > lim_x)       corr = lim_x;
              else if (neg_x < -lim_x) corr = -lim_x;
              else                     corr = neg_x;
            end
          end
        end
      endcase
      ph_d = ph_q + STEP + $unsigned(corr[PH_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      msb_q  <= 1'b0;
      half_q <= 1'b0;
      acc_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      msb_q  <= ph_q[PH_W-1];
      half_q <= half_d;
      acc_q  <= acc_d;
    end
  end

  assign ph     = ph_q;
  assign strobe = ph_q[PH_W-1] & ~msb_q;

endmodule

// File: rtl/bitclk_dpll.sv
module bitclk_dpll
  import bitclk_dpll_pkg::*;
#(
  parameter int STEPS_PER_BIT = 16,
  parameter int FINE_BITS     = 2,
  parameter int MED_BITS      = 30,
  parameter int MED_DIV       = 16,
  parameter int NAR_DIV       = 64,
  parameter int ACQ_SHIFT     = 0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             os_en,
  input  logic                             rx_sign,
  input  logic                             acq_req,
  input  logic                             track_en,
  output logic                             rx_clk,
  output logic                             mid_strobe,
  output logic [$clog2(STEPS_PER_BIT)-1:0] exp_phase
);

  localparam int STEP_W  = $clog2(STEPS_PER_BIT);
  localparam int PH_W    = STEP_W + FINE_BITS;
  localparam int FULL    = 1 << PH_W;
  localparam int MED_LIM = FULL / MED_DIV;
  localparam int NAR_LIM = FULL / NAR_DIV;

  logic [1:0]             rst_pipe;
  logic                   rst_n_s;
  logic [PH_W-1:0]        ph;
  logic                   xing;
  logic signed [PH_W-1:0] err;
  logic                   strobe;
  loop_mode_e             mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  bitclk_xing_det #(.PH_W(PH_W)) u_xing (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .os_en   (os_en),
    .rx_sign (rx_sign),
    .ph      (ph),
    .xing    (xing),
    .err     (err)
  );

  bitclk_mode_ctrl #(.MED_BITS(MED_BITS)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .acq_req  (acq_req),
    .track_en (track_en),
    .bit_tick (strobe),
    .mode     (mode)
  );

  bitclk_phase_nco #(
    .PH_W      (PH_W),
    .FINE_BITS (FINE_BITS),
    .MED_LIM   (MED_LIM),
    .NAR_LIM   (NAR_LIM),
    .ACQ_SHIFT (ACQ_SHIFT)
  ) u_nco (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .os_en  (os_en),
    .xing   (xing),
    .err    (err),
    .mode   (mode),
    .ph     (ph),
    .strobe (strobe)
  );

  assign rx_clk     = ph[PH_W-1];
  assign mid_strobe = strobe;
  assign exp_phase  = ph[PH_W-1:FINE_BITS];

endmodule

// File: rtl/bitclk_dpll_chk.sv
module bitclk_dpll_chk
  import bitclk_dpll_pkg::*;
#(
  parameter int STEPS_PER_BIT = 16,
  parameter int FINE_BITS     = 2,
  parameter int MED_DIV       = 16,
  parameter int NAR_DIV       = 64,
  parameter int ACQ_SHIFT     = 0
) (
  input logic                                   clk,
  input logic                                   rst_n_s,
  input logic                                   os_en,
  input logic                                   xing,
  input logic                                   mid_strobe,
  input logic [$clog2(STEPS_PER_BIT)+FINE_BITS-1:0] ph,
  input loop_mode_e                             mode
);

  localparam int PH_W    = $clog2(STEPS_PER_BIT) + FINE_BITS;
  localparam int STEP    = 1 << FINE_BITS;
  localparam int MED_LIM = (1 << PH_W) / MED_DIV;
  localparam int NAR_LIM = (1 << PH_W) / NAR_DIV;

  a_r2_still_without_tick: assert property (@(posedge clk) disable iff (!rst_n_s)
    !os_en |=> $stable(ph));

  a_r3_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n_s)
    mid_strobe |-> $past(os_en));

  a_r5_acquire_lands_on_boundary: assert property (@(posedge clk) disable iff (!rst_n_s)
    (xing && mode == MODE_ACQ && ACQ_SHIFT == 0) |=> (int'(ph) == STEP));

  a_r6_medium_step_bounded: assert property (@(posedge clk) disable iff (!rst_n_s)
    (os_en && mode == MODE_MED) |=>
      (int'(PH_W'(ph - $past(ph))) >= STEP - MED_LIM &&
       int'(PH_W'(ph - $past(ph))) <= STEP + MED_LIM));

  a_r7_narrow_step_bounded: assert property (@(posedge clk) disable iff (!rst_n_s)
    (os_en && mode == MODE_NAR) |=>
      (int'(PH_W'(ph - $past(ph))) >= STEP - NAR_LIM &&
       int'(PH_W'(ph - $past(ph))) <= STEP + NAR_LIM));

  a_r8_no_return_to_medium: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == MODE_NAR) |=> (mode != MODE_MED));

  a_r9_hold_freewheels: assert property (@(posedge clk) disable iff (!rst_n_s)
    (os_en && mode == MODE_HOLD) |=> (int'(PH_W'(ph - $past(ph))) == STEP));

endmodule

bind bitclk_dpll bitclk_dpll_chk #(
  .STEPS_PER_BIT (STEPS_PER_BIT),
  .FINE_BITS     (FINE_BITS),
  .MED_DIV       (MED_DIV),
  .NAR_DIV       (NAR_DIV),
  .ACQ_SHIFT     (ACQ_SHIFT)
) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .os_en      (os_en),
  .xing       (xing),
  .mid_strobe (mid_strobe),
  .ph         (ph),
  .mode       (mode)
);

// File: tb/bitclk_dpll_tb.sv
`timescale 1ns/1ps
module bitclk_dpll_tb;

  logic       clk;
  logic       rst_n;
  logic       os_en;
  logic       rx_sign;
  logic       acq_req;
  logic       track_en;
  logic       rx_clk;
  logic       mid_strobe;
  logic [3:0] exp_phase;

  int checks;
  int errors;
  int high_cnt;
  int strobe_cnt;
  bit done;
  logic cur;

  typedef struct {
    int    kind;
    int    expv;
    string req;
  } item_t;

  item_t q[$];
  event  chk_ev;

  bitclk_dpll u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_en      (os_en),
    .rx_sign    (rx_sign),
    .acq_req    (acq_req),
    .track_en   (track_en),
    .rx_clk     (rx_clk),
    .mid_strobe (mid_strobe),
    .exp_phase  (exp_phase)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Monitor: pops expected items and compares with what the design shows.
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        int got;
        it = q.pop_front();
        case (it.kind)
          0: got = int'(exp_phase);
          1: got = high_cnt;
          2: got = strobe_cnt;
          3: got = int'(rx_clk);
          default: got = int'(mid_strobe);
        endcase
        checks++;
        if (got != it.expv) begin
          errors++;
          $display("FAIL %s kind %0d: got %0d expected %0d", it.req, it.kind, got, it.expv);
        end
      end
    end
  end

  task automatic expect_val(input int kind, input int expv, input string req);
    item_t it;
    it.kind = kind;
    it.expv = expv;
    it.req  = req;
    q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  // One oversample tick: two clocks, os_en high in the first.
  task automatic step(input logic s);
    rx_sign = s;
    os_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    os_en = 1'b0;
    if (mid_strobe) strobe_cnt++;
    @(posedge clk);
    @(negedge clk);
    if (rx_clk) high_cnt++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(cur);
  endtask

  task automatic toggle();
    cur = ~cur;
    step(cur);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; high_cnt = 0; strobe_cnt = 0; done = 0;
    cur = 1'b0;
    rst_n = 1'b0; os_en = 1'b0; rx_sign = 1'b0; acq_req = 1'b0; track_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    expect_val(0, 0, "R1");
    expect_val(3, 0, "R1");
    expect_val(4, 0, "R1");

    // R2 free running and stability between ticks
    run(20);
    expect_val(0, 4, "R2");
    repeat (5) @(negedge clk);
    expect_val(0, 4, "R2 no tick");

    // R3 duty and strobe count over one bit
    high_cnt = 0; strobe_cnt = 0;
    run(16);
    expect_val(1, 8, "R3 duty");
    expect_val(2, 1, "R3 strobe");
    expect_val(0, 4, "R2 wrap");

    // long run with tracking on: timer reaches narrow
    run(640);
    expect_val(0, 4, "R2 long");

    // R5 acquire, track_en low is ignored
    acq_req = 1'b1; track_en = 1'b0;
    toggle();
    expect_val(0, 1, "R5");
    run(5);
    expect_val(0, 6, "R5 pre");
    toggle();
    expect_val(0, 1, "R5 track ignored");
    run(10);
    expect_val(0, 11, "R5 pre");
    toggle();
    expect_val(0, 1, "R4 negative error in acquire");

    // R6 medium after release; acquire cleared the timer (R8)
    acq_req = 1'b0; track_en = 1'b1;
    toggle();
    expect_val(0, 2, "R6 first of pair uncorrected");
    toggle();
    toggle();
    toggle();
    expect_val(0, 3, "R6 R8 medium clamp");
    run(9);
    expect_val(0, 12, "R2");
    toggle();
    expect_val(0, 13, "R6");
    toggle();
    expect_val(0, 15, "R6 R4 negative pair");

    // R9 hold: no correction, clock keeps running
    track_en = 1'b0;
    strobe_cnt = 0;
    toggle();
    expect_val(0, 0, "R9");
    toggle();
    expect_val(0, 1, "R9 pair ignored");
    run(638);
    expect_val(0, 15, "R9 freewheel");
    expect_val(2, 40, "R9 clock keeps running");

    // R8 timer frozen in hold: still medium
    track_en = 1'b1;
    run(5);
    expect_val(0, 4, "R2");
    toggle(); toggle(); toggle(); toggle();
    expect_val(0, 6, "R8 still medium after hold");

    // R7 narrow after 30 tracked bits
    run(640);
    expect_val(0, 6, "R2");
    run(11);
    expect_val(0, 1, "R2");
    toggle(); toggle();
    expect_val(0, 2, "R7");
    toggle(); toggle();
    expect_val(0, 4, "R7 R8 narrow clamp");

    #5;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule